// File: doc/BRIEF.md
# Smart Card Character Launch Controller

This block decides when a character written by a host is sent to a smart card over a single half-duplex I/O line, and then sends it. A host write strobe loads an 8-bit value into a holding register. When the line is free, a serializer sends the value as one asynchronous frame. The frame has a low start bit, the eight data bits with bit 0 first, and an even parity bit. Each bit lasts one elementary time unit (ETU), whose length in clock cycles is set by a divider input. After the parity bit the line stays high for a programmable number of extra guard ETUs. Only then may the next character start.

A write that arrives while a frame or its guard interval is still running is kept as pending. It is launched on the very clock edge on which the guard interval ends, so no idle cycle sits between the two frames. A later write overwrites a character that is still pending. A synchronous-card mode bypasses framing altogether: each write copies bit 0 of the written value straight onto the card line.

Top module: `sc_tx_launch`

## Requirements
- R1: After a synchronous reset the card line is high (released) and `busy` is low.
- R2: A write is the clock edge at which `wr_stb` is sampled high after being sampled low at the previous edge. With the block idle and `sync_mode` low, a write at edge k drives the start bit from edge k+1 onward. `busy` rises at that same edge.
- R3: A frame is one low start bit, then `wr_data` bits 0 through 7 (bit 0 first, 1 sent as high), then one even parity bit that makes the count of ones in data plus parity even. Each bit lasts `etu_div` clock cycles.
- R4: After the parity bit the line stays high for `guard_etu` ETUs. `busy` stays high from the start bit until the end of that interval. Whenever `busy` is low, the line is high.
- R5: A write made during the guard interval is held. Its start bit begins on the edge at which the guard interval ends.
- R6: A write made while a frame is being shifted out does not disturb that frame. It is held and sent after that frame's guard interval.
- R7: A second write while a character is still pending replaces the pending character. Only the later value is sent.
- R8: With `guard_etu` = 0, a pending character starts on the edge at which the parity bit ends, so frames run back to back.
- R9: With `sync_mode` high, a write copies `wr_data[0]` onto the card line from the next edge onward. No frame is sent and `busy` stays low.
- R10: Holding `wr_stb` high for many cycles counts as a single write.
- R11: An `etu_div` value of 0 is treated as 1, giving one clock cycle per bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_stb | input | 1 | Host write strobe; its rising edge is one write |
| wr_data | input | 8 | Character to send, bit 0 sent first |
| sync_mode | input | 1 | High selects synchronous-card pass-through of bit 0 |
| etu_div | input | 12 | Clock cycles per ETU (0 acts as 1) |
| guard_etu | input | 8 | Extra guard time in ETUs after the parity bit |
| card_io | output | 1 | Level driven onto the card I/O line |
| busy | output | 1 | Frame or guard interval in progress |

## Verification
The bench sends characters with alternating bit patterns, all-ones and all-zeros values, and odd-weight values. These show whether the bit order is right and whether the parity bit is computed or fixed. Writes are placed at three points: on an idle line, in the middle of the data bits, and inside the guard interval. Comparing these runs separates "held until the guard ends" from "dropped" and from "started at once". A zero guard interval and a zero divider test the edge timing of back-to-back launch and the one-cycle ETU. The run ends with a long held strobe and synchronous-mode writes. These show whether a level is wrongly taken as repeated writes, and whether pass-through wrongly starts a frame.

// File: rtl/sc_tx_pkg.sv
package sc_tx_pkg;

    typedef enum logic [1:0] {
        SER_IDLE  = 2'd0,
        SER_SHIFT = 2'd1,
        SER_GUARD = 2'd2
    } ser_state_e;

endpackage

// File: rtl/sc_etu_ticker.sv
module sc_etu_ticker #(
    parameter int ETU_W = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             restart_i,
    input  logic [ETU_W-1:0] div_i,
    output logic             tick_o
);

    typedef struct packed {
        logic [ETU_W-1:0] cnt;
    } tick_state_t;

    tick_state_t st_d, st_q;
    logic [ETU_W-1:0] div_eff;

    always_comb begin
        div_eff = (div_i == '0) ? ETU_W'(1) : div_i;
        tick_o  = (st_q.cnt >= div_eff - ETU_W'(1));
        st_d    = st_q;
        if (restart_i || tick_o) begin
            st_d.cnt = '0;
        end else begin
            st_d.cnt = st_q.cnt + ETU_W'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    p_restart_zero_r3: assert property (@(posedge clk) disable iff (rst)
        restart_i |=> (st_q.cnt == '0));

    p_unit_div_tick_r11: assert property (@(posedge clk) disable iff (rst)
        (div_i == '0) && $stable(div_i) && !$past(restart_i) |-> tick_o);

endmodule

// File: rtl/sc_tx_holding.sv
module sc_tx_holding #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              load_i,
    input  logic [DATA_W-1:0] data_i,
    input  logic              take_i,
    output logic              pend_o,
    output logic [DATA_W-1:0] data_o
);

    typedef struct packed {
        logic              pend;
        logic [DATA_W-1:0] data;
    } hold_state_t;

    hold_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (load_i) begin
            st_d.pend = 1'b1;
            st_d.data = data_i;
        end else if (take_i) begin
            st_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign pend_o = st_q.pend;
    assign data_o = st_q.data;

    p_take_clears_r6: assert property (@(posedge clk) disable iff (rst)
        take_i && !load_i |=> !pend_o);

    p_latest_wins_r7: assert property (@(posedge clk) disable iff (rst)
        load_i |=> pend_o && (data_o == $past(data_i)));

endmodule

// File: rtl/sc_tx_serializer.sv
module sc_tx_serializer
    import sc_tx_pkg::*;
#(
    parameter int DATA_W  = 8,
    parameter int GUARD_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               start_i,
    input  logic [DATA_W-1:0]  data_i,
    input  logic [GUARD_W-1:0] guard_i,
    input  logic               tick_i,
    output logic               ready_o,
    output logic               io_o,
    output logic               busy_o
);

    localparam int LAST_IDX = DATA_W + 1;
    localparam int IDX_W    = $clog2(DATA_W + 2);

    typedef struct packed {
        ser_state_e        state;
        logic [IDX_W-1:0]  idx;
        logic [DATA_W:0]   shreg;
        logic [GUARD_W-1:0] gcnt;
        logic              io;
    } ser_state_t;

    ser_state_t st_d, st_q;
    logic at_last;
    logic guard_last;

    always_comb begin
        at_last    = (st_q.idx == IDX_W'(LAST_IDX));
        guard_last = (st_q.gcnt == GUARD_W'(1));
        ready_o    = (st_q.state == SER_IDLE)
                   || (tick_i && st_q.state == SER_SHIFT && at_last && st_q.gcnt == '0)
                   || (tick_i && st_q.state == SER_GUARD && guard_last);
        st_d = st_q;
        if (start_i) begin
            st_d.state = SER_SHIFT;
            st_d.idx   = '0;
            st_d.shreg = {^data_i, data_i};
            st_d.gcnt  = guard_i;
            st_d.io    = 1'b0;
        end else if (tick_i) begin
            case (st_q.state)
                SER_SHIFT: begin
                    if (at_last) begin
                        st_d.io    = 1'b1;
                        st_d.state = (st_q.gcnt == '0) ? SER_IDLE : SER_GUARD;
                    end else begin
                        st_d.io    = st_q.shreg[0];
                        st_d.shreg = {1'b0, st_q.shreg[DATA_W:1]};
                        st_d.idx   = st_q.idx + IDX_W'(1);
                    end
                end
                SER_GUARD: begin
                    st_d.io   = 1'b1;
                    st_d.gcnt = st_q.gcnt - GUARD_W'(1);
                    if (guard_last) begin
                        st_d.state = SER_IDLE;
                    end
                end
                default: begin
                    st_d.io = 1'b1;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.state <= SER_IDLE;
            st_q.idx   <= '0;
            st_q.shreg <= '0;
            st_q.gcnt  <= '0;
            st_q.io    <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign io_o   = st_q.io;
    assign busy_o = (st_q.state != SER_IDLE);

    p_start_bit_low_r3: assert property (@(posedge clk) disable iff (rst)
        start_i |=> (!io_o && busy_o));

    p_guard_high_r4: assert property (@(posedge clk) disable iff (rst)
        (st_q.state == SER_GUARD) |-> io_o);

    p_idle_released_r4: assert property (@(posedge clk) disable iff (rst)
        !busy_o |-> io_o);

    p_start_only_ready_r6: assert property (@(posedge clk) disable iff (rst)
        start_i |-> ready_o);

endmodule

// File: rtl/sc_tx_launch.sv
module sc_tx_launch #(
    parameter int DATA_W  = 8,
    parameter int ETU_W   = 12,
    parameter int GUARD_W = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_stb,
    input  logic [DATA_W-1:0]  wr_data,
    input  logic               sync_mode,
    input  logic [ETU_W-1:0]   etu_div,
    input  logic [GUARD_W-1:0] guard_etu,
    output logic               card_io,
    output logic               busy
);

    typedef struct packed {
        logic wr_prev;
        logic sync_bit;
    } top_state_t;

    top_state_t st_d, st_q;
    logic wr_evt;
    logic load;
    logic start;
    logic pend;
    logic [DATA_W-1:0] pend_data;
    logic ser_ready;
    logic ser_io;
    logic tick;

    always_comb begin
        wr_evt = wr_stb && !st_q.wr_prev;
        load   = wr_evt && !sync_mode;
        start  = pend && ser_ready && !sync_mode;
        st_d   = st_q;
        st_d.wr_prev = wr_stb;
        if (wr_evt && sync_mode) begin
            st_d.sync_bit = wr_data[0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st_q.wr_prev  <= 1'b0;
            st_q.sync_bit <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    sc_etu_ticker #(.ETU_W(ETU_W)) u_ticker (
        .clk       (clk),
        .rst       (rst),
        .restart_i (start),
        .div_i     (etu_div),
        .tick_o    (tick)
    );

    sc_tx_holding #(.DATA_W(DATA_W)) u_hold (
        .clk    (clk),
        .rst    (rst),
        .load_i (load),
        .data_i (wr_data),
        .take_i (start),
        .pend_o (pend),
        .data_o (pend_data)
    );

    sc_tx_serializer #(.DATA_W(DATA_W), .GUARD_W(GUARD_W)) u_ser (
        .clk     (clk),
        .rst     (rst),
        .start_i (start),
        .data_i  (pend_data),
        .guard_i (guard_etu),
        .tick_i  (tick),
        .ready_o (ser_ready),
        .io_o    (ser_io),
        .busy_o  (busy)
    );

    assign card_io = sync_mode ? st_q.sync_bit : ser_io;

    p_sync_copy_r9: assert property (@(posedge clk) disable iff (rst)
        (sync_mode && wr_evt) |=> (!sync_mode || card_io == $past(wr_data[0])));

    p_sync_no_launch_r9: assert property (@(posedge clk) disable iff (rst)
        (sync_mode && !busy) |=> !busy);

    p_level_single_r10: assert property (@(posedge clk) disable iff (rst)
        (wr_stb && $past(wr_stb)) |-> !load);

    p_idle_write_busy_r2: assert property (@(posedge clk) disable iff (rst)
        (load && !busy && !pend) |=> ##1 busy);

endmodule

// File: tb/test_sc_tx_launch.sv
module test_sc_tx_launch;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       wr_stb = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic       sync_mode = 1'b0;
    logic [11:0] etu_div = 12'd3;
    logic [7:0] guard_etu = 8'd2;
    logic       card_io;
    logic       busy;

    int n_tests = 0;
    int n_fail  = 0;
    string cur_req = "R1";
    bit checking = 1'b0;

    // behavioural reference state
    bit m_q[$];
    bit m_pend = 0;
    bit [7:0] m_pdata = 0;
    bit m_sync = 1;
    bit m_prev = 0;
    bit m_io = 1;
    bit m_busy = 0;

    always #10 clk = ~clk;

    sc_tx_launch i_sc_tx_launch (
        .clk       (clk),
        .rst       (rst),
        .wr_stb    (wr_stb),
        .wr_data   (wr_data),
        .sync_mode (sync_mode),
        .etu_div   (etu_div),
        .guard_etu (guard_etu),
        .card_io   (card_io),
        .busy      (busy)
    );

    always @(posedge clk) begin
        if (rst) begin
            m_q.delete();
            m_pend = 0;
            m_sync = 1;
            m_prev = 0;
            m_io = 1;
            m_busy = 0;
        end else begin
            automatic bit evt = wr_stb && !m_prev;
            if (m_pend && m_q.size() == 0 && !sync_mode) begin
                automatic int dv = (etu_div == 0) ? 1 : int'(etu_div);
                automatic bit lv[$];
                lv.push_back(1'b0);
                for (int b = 0; b < 8; b++) lv.push_back(m_pdata[b]);
                lv.push_back(^m_pdata);
                for (int g = 0; g < int'(guard_etu); g++) lv.push_back(1'b1);
                foreach (lv[i]) for (int r = 0; r < dv; r++) m_q.push_back(lv[i]);
                m_pend = 0;
            end
            if (evt) begin
                if (sync_mode) m_sync = wr_data[0];
                else begin
                    m_pend = 1;
                    m_pdata = wr_data;
                end
            end
            if (m_q.size() > 0) begin
                m_io = m_q.pop_front();
                m_busy = 1;
            end else begin
                m_io = 1;
                m_busy = 0;
            end
            m_prev = wr_stb;
        end
    end

    always @(negedge clk) begin
        if (checking && !rst) begin
            automatic bit exp_io = sync_mode ? m_sync : m_io;
            n_tests++;
            if (card_io !== exp_io || busy !== m_busy) begin
                n_fail++;
                $display("FAIL %s: io/busy actual %b/%b expected %b/%b at %0t",
                         cur_req, card_io, busy, exp_io, m_busy, $time);
            end
        end
    end

    task automatic host_write(input logic [7:0] d);
        @(negedge clk);
        wr_stb = 1'b1;
        wr_data = d;
        @(negedge clk);
        wr_stb = 1'b0;
    endtask

    task automatic idle_for(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL R2: watchdog expired, actual running expected finished");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        idle_for(3);
        // R1: reset state
        n_tests++;
        if (card_io !== 1'b1 || busy !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: io/busy actual %b/%b expected 1/0", card_io, busy);
        end
        rst = 1'b0;
        checking = 1'b1;
        idle_for(4);

        // R2, R3, R4: idle launch, several patterns
        cur_req = "R2";
        host_write(8'hA5);
        cur_req = "R3";
        idle_for(45);
        cur_req = "R4";
        host_write(8'h01);
        idle_for(45);
        cur_req = "R3";
        host_write(8'hFF);
        idle_for(45);
        host_write(8'h00);
        idle_for(45);

        // R11: zero divider acts as one cycle per bit
        cur_req = "R11";
        etu_div = 12'd0;
        host_write(8'h3C);
        idle_for(20);
        host_write(8'h07);
        idle_for(20);
        etu_div = 12'd3;

        // R6: write during data bits held until after guard
        cur_req = "R6";
        host_write(8'h5A);
        idle_for(6);
        host_write(8'hC3);
        idle_for(90);

        // R5: write inside guard interval
        cur_req = "R5";
        guard_etu = 8'd4;
        host_write(8'h96);
        idle_for(32);
        host_write(8'h69);
        idle_for(110);

        // R7: later pending write replaces earlier
        cur_req = "R7";
        guard_etu = 8'd2;
        host_write(8'h11);
        idle_for(3);
        host_write(8'h22);
        idle_for(3);
        host_write(8'hE4);
        idle_for(90);

        // R8: zero guard, back to back
        cur_req = "R8";
        guard_etu = 8'd0;
        host_write(8'h81);
        idle_for(2);
        host_write(8'h7E);
        idle_for(75);
        guard_etu = 8'd2;

        // R10: strobe held high is one write
        cur_req = "R10";
        @(negedge clk);
        wr_data = 8'hB2;
        wr_stb = 1'b1;
        idle_for(120);
        wr_stb = 1'b0;
        idle_for(10);

        // R9: synchronous-card pass-through
        cur_req = "R9";
        sync_mode = 1'b1;
        idle_for(2);
        host_write(8'h00);
        idle_for(3);
        host_write(8'hFF);
        idle_for(3);
        host_write(8'h02);
        idle_for(3);
        host_write(8'h01);
        idle_for(5);
        sync_mode = 1'b0;
        idle_for(5);

        checking = 1'b0;
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule